// File: doc/BRIEF.md
# Four-Way Prioritised DMA Word Channel

This block lets four hardware engines share one word-wide access path into a DSP's memory system. The four engines are a serial radio front end, an error-correction codec, a two-wire bus master/slave and a host port. Each engine owns a base-address register and a block-size register, loaded through a small configuration write port. An engine raises its request line to ask for service. For every word it is given, the block puts one read or write on the memory port, aimed at the X, Y or P data memory or at the core's register space, and pulses that engine's acknowledge.

Each engine has its own running address and remaining-word counter. A higher-priority engine can therefore cut into a lower one's block at any word boundary. An engine that drops its request part way through keeps its place and resumes later. When an engine's block runs out, its own completion flag is raised. The flag stays up until the engine releases its request or pulses its clear line. The memory is treated as a plain single-cycle word port: read data returns combinationally in the same cycle as the access.

Top module: `dma_chan_arb`

## Requirements
- R1: A configuration write with `cfg_field`=0 loads source `cfg_sel`'s base address from `cfg_wdata`, and `cfg_field`=1 loads its block size from `cfg_wdata[LEN_W-1:0]`. The values are taken when that source next begins a block. A write made while a block is running leaves that block's length and addresses unchanged.
- R2: At most one acknowledge is high in any cycle. It goes to the lowest-numbered source that is eligible, where eligible means requesting, not flagged done, and with words left. Arbitration is redone on every word, so a lower source's block is interrupted word by word by a higher source.
- R3: During an access, `mem_we` equals the winner's `req_wr` bit, `mem_space` equals its 2-bit space code (0 = X, 1 = Y, 2 = P, 3 = core registers), and `mem_wdata` equals its data word. `rdata` carries `mem_rdata` in the same cycle.
- R4: `ack[s]` is high in exactly those cycles in which source s's word is on the memory port with `mem_en` high. `mem_en` is low when no source is served.
- R5: The first word of a block goes to the base address. Each following word of the same source goes to the previous address plus one, wrapping at the address width.
- R6: A block size of L (L ≥ 1) produces exactly L acknowledged words. `done[s]` rises in the cycle after the last one. A size of 1 is a single-word access.
- R7: A block size of 0 sets `done[s]` one cycle after the request is seen, with no memory access for that source.
- R8: `done[s]` holds while `req[s]` stays high, and while it is high the source gets no access. It clears on the cycle after `req[s]` is low or `done_clr[s]` is pulsed. When a clear and a completion fall in the same cycle, the completion wins. After a clear with the request still high, a new block starts from the base register.
- R9: Dropping `req[s]` in the middle of a block pauses it. When the request returns, the block continues at the next address with the remaining count.
- R10: After reset there is no acknowledge, `mem_en` is low, every `done` bit is low, and every base and size register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Source whose register is written |
| cfg_field | input | 1 | 0 = base address, 1 = block size |
| cfg_wdata | input | ADDR_W | Configuration write value |
| done_clr | input | N_SRC | Per-source completion-flag clear |
| req | input | N_SRC | Per-source request |
| req_wr | input | N_SRC | Per-source direction, 1 = write |
| req_space | input | 2*N_SRC | Per-source memory space code |
| req_wdata | input | N_SRC*DATA_W | Per-source write data |
| ack | output | N_SRC | Per-source word acknowledge |
| done | output | N_SRC | Per-source sticky block-complete flag |
| rdata | output | DATA_W | Read data returned to the served source |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_space | output | 2 | Memory space select |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |

## Verification
The hardest state to reach is a block that has been both preempted and paused. That block has to come back at the correct next address with the correct remaining count, while another source is claiming the channel. The stimulus starts a low-priority block and raises a higher source two words in. Later it withdraws and restores the low source's request mid-block, and it rewrites that source's size register while the block is still running. A behavioural model in the bench tracks each source's position and is compared against every port on every cycle, so any lost or duplicated word shows up at once.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    SPACE_X   = 2'd0,
    SPACE_Y   = 2'd1,
    SPACE_P   = 2'd2,
    SPACE_REG = 2'd3
  } dsp_space_e;

  typedef enum logic {
    FIELD_BASE = 1'b0,
    FIELD_SIZE = 1'b1
  } cfg_field_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N_IN = 4,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0] cand,
  output logic [N_IN-1:0] onehot,
  output logic [IW-1:0]   idx,
  output logic            any
);
  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
    if (any) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/dma_src_ctx.sv
module dma_src_ctx #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_size,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              req,
  input  logic              clr,
  input  logic              grant,
  output logic              elig,
  output logic              empty_hit,
  output logic              last_word,
  output logic [ADDR_W-1:0] word_addr,
  output logic              done
);
  logic [ADDR_W-1:0] base_q, cur_q;
  logic [LEN_W-1:0]  size_q, left_q, eff_left;
  logic              busy_q;

  function automatic logic [ADDR_W-1:0] addr_after(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] count_after(input logic [LEN_W-1:0] c);
    return c - LEN_W'(1);
  endfunction

  // an idle source reads straight from its registers, a busy one from its counters
  assign word_addr = busy_q ? cur_q  : base_q;
  assign eff_left  = busy_q ? left_q : size_q;
  assign elig      = req && !done && (eff_left != '0);
  assign empty_hit = req && !done && !busy_q && (size_q == '0);
  assign last_word = (eff_left == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      cur_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_size) size_q <= wdata[LEN_W-1:0];
      if (grant) begin
        if (last_word) begin
          busy_q <= 1'b0;
        end else begin
          busy_q <= 1'b1;
          cur_q  <= addr_after(word_addr);
          left_q <= count_after(eff_left);
        end
      end
      if ((grant && last_word) || empty_hit) done <= 1'b1;
      else if (!req || clr)                 done <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
  import dma_arb_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic                      cfg_field,
  input  logic [ADDR_W-1:0]         cfg_wdata,
  input  logic [N_SRC-1:0]          done_clr,
  input  logic [N_SRC-1:0]          req,
  input  logic [N_SRC-1:0]          req_wr,
  input  logic [2*N_SRC-1:0]        req_space,
  input  logic [N_SRC*DATA_W-1:0]   req_wdata,
  output logic [N_SRC-1:0]          ack,
  output logic [N_SRC-1:0]          done,
  output logic [DATA_W-1:0]         rdata,
  output logic                      mem_en,
  output logic                      mem_we,
  output logic [1:0]                mem_space,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata
);
  // named internal events, observed by the bound checker
  logic [N_SRC-1:0]  elig_vec;
  logic [N_SRC-1:0]  empty_vec;
  logic [N_SRC-1:0]  last_vec;
  logic [N_SRC-1:0]  blk_end_vec;
  logic [N_SRC-1:0]  grant_vec;
  logic [SEL_W-1:0]  win_idx;
  logic              word_fire;
  logic [ADDR_W-1:0] addr_arr [N_SRC];

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic hit_sel;
    assign hit_sel = cfg_we && (cfg_sel == SEL_W'(s));
    dma_src_ctx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_base   (hit_sel && (cfg_field == FIELD_BASE)),
      .wr_size   (hit_sel && (cfg_field == FIELD_SIZE)),
      .wdata     (cfg_wdata),
      .req       (req[s]),
      .clr       (done_clr[s]),
      .grant     (grant_vec[s]),
      .elig      (elig_vec[s]),
      .empty_hit (empty_vec[s]),
      .last_word (last_vec[s]),
      .word_addr (addr_arr[s]),
      .done      (done[s])
    );
  end

  dma_prio_pick #(.N_IN(N_SRC)) u_pick (
    .cand   (elig_vec),
    .onehot (grant_vec),
    .idx    (win_idx),
    .any    (word_fire)
  );

  assign blk_end_vec = grant_vec & last_vec;
  assign ack         = grant_vec;
  assign mem_en      = word_fire;
  assign mem_we      = word_fire && req_wr[win_idx];
  assign mem_space   = word_fire ? req_space[win_idx*2 +: 2] : 2'd0;
  assign mem_addr    = word_fire ? addr_arr[win_idx] : '0;
  assign mem_wdata   = word_fire ? req_wdata[win_idx*DATA_W +: DATA_W] : '0;
  assign rdata       = mem_rdata;
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req,
  input logic [N_SRC-1:0] done_clr,
  input logic [N_SRC-1:0] ack,
  input logic [N_SRC-1:0] done,
  input logic [N_SRC-1:0] elig_vec,
  input logic [N_SRC-1:0] empty_vec,
  input logic [N_SRC-1:0] blk_end_vec
);
  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> ((elig_vec & (ack - N_SRC'(1))) == '0));

  p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~req) == '0));

  p_done_from_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((done & ~$past(done) & ~($past(blk_end_vec) | $past(empty_vec))) == '0));

  p_empty_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((empty_vec & ack) == '0));

  p_done_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ack) == '0));

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(done) & (~$past(req) | $past(done_clr))
               & ~($past(blk_end_vec) | $past(empty_vec)) & done) == '0));
endmodule

bind dma_chan_arb dma_chan_arb_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .done_clr    (done_clr),
  .ack         (ack),
  .done        (done),
  .elig_vec    (elig_vec),
  .empty_vec   (empty_vec),
  .blk_end_vec (blk_end_vec)
);

// File: tb/sim_dma_chan_arb.sv
module sim_dma_chan_arb;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic          cfg_field = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [N-1:0]  done_clr = '0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  req_wr = 4'b0101;
  logic [2*N-1:0] req_space = {2'd3, 2'd2, 2'd1, 2'd0};
  logic [N*DW-1:0] req_wdata = {16'hD333, 16'hC222, 16'hB111, 16'hA000};
  logic [N-1:0]  ack, done;
  logic [DW-1:0] rdata, mem_rdata;
  logic          mem_en, mem_we;
  logic [1:0]    mem_space;
  logic [AW-1:0] mem_addr, mem_wdata;

  always #4 clk = ~clk;

  dma_chan_arb u0 (.*);

  function automatic logic [DW-1:0] mem_fn(input logic [1:0] sp, input logic [AW-1:0] a);
    return {sp, a[13:0]} ^ 16'hA5C3;
  endfunction
  assign mem_rdata = mem_fn(mem_space, mem_addr);

  int n_chk = 0, n_bad = 0;
  int acks [N];
  logic [AW-1:0] last_addr [N];

  // reference model state
  logic [AW-1:0] m_base [N], m_cur [N];
  int  m_size [N], m_left [N];
  bit  m_busy [N], m_done [N];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    int win;
    logic [AW-1:0] ea;
    logic [N-1:0] e_ack, e_done;
    #1;
    win = -1;
    ea = '0;
    for (int s = N - 1; s >= 0; s--) begin
      int er;
      er = m_busy[s] ? m_left[s] : m_size[s];
      if (req[s] && !m_done[s] && er != 0) begin
        win = s;
        ea = m_busy[s] ? m_cur[s] : m_base[s];
      end
    end
    e_ack = '0;
    if (win >= 0) e_ack[win] = 1'b1;
    for (int s = 0; s < N; s++) e_done[s] = m_done[s];
    chk(ack == e_ack, "R2", "ack", ack, e_ack);
    chk(mem_en == (win >= 0), "R4", "mem_en", mem_en, win >= 0);
    chk(done == e_done, "R8", "done", done, e_done);
    if (win >= 0) begin
      chk(mem_addr == ea, "R5", "mem_addr", mem_addr, ea);
      chk(mem_we == req_wr[win], "R3", "mem_we", mem_we, req_wr[win]);
      chk(mem_space == req_space[win*2 +: 2], "R3", "mem_space", mem_space, req_space[win*2 +: 2]);
      chk(mem_wdata == req_wdata[win*DW +: DW], "R3", "mem_wdata", mem_wdata, req_wdata[win*DW +: DW]);
      chk(rdata == mem_fn(req_space[win*2 +: 2], ea), "R3", "rdata", rdata,
          mem_fn(req_space[win*2 +: 2], ea));
    end
    for (int s = 0; s < N; s++)
      if (ack[s]) begin
        acks[s]++;
        last_addr[s] = mem_addr;
      end
    @(posedge clk);
    for (int s = 0; s < N; s++) begin
      int er;
      er = m_busy[s] ? m_left[s] : m_size[s];
      if (s == win) begin
        if (er == 1) begin
          m_busy[s] = 1'b0;
          m_done[s] = 1'b1;
        end else begin
          m_busy[s] = 1'b1;
          m_cur[s] = ea + 1'b1;
          m_left[s] = er - 1;
        end
      end else if (req[s] && !m_done[s] && !m_busy[s] && m_size[s] == 0) begin
        m_done[s] = 1'b1;
      end else if (!req[s] || done_clr[s]) begin
        m_done[s] = 1'b0;
      end
    end
    if (cfg_we) begin
      if (cfg_field) m_size[cfg_sel] = int'(cfg_wdata[LW-1:0]);
      else           m_base[cfg_sel] = cfg_wdata;
    end
    @(negedge clk);
  endtask

  task automatic cfg(input int s, input bit f, input logic [AW-1:0] v);
    cfg_we = 1'b1;
    cfg_sel = 2'(s);
    cfg_field = f;
    cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic run_to_done(input int s, input int lim, input string tag);
    for (int i = 0; i < lim && !done[s]; i++) step();
    chk(done[s] == 1'b1, tag, "done reached", done[s], 1);
  endtask

  task automatic zero_acks();
    for (int s = 0; s < N; s++) acks[s] = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) begin
      m_base[s] = '0; m_cur[s] = '0; m_size[s] = 0; m_left[s] = 0;
      m_busy[s] = 1'b0; m_done[s] = 1'b0; acks[s] = 0; last_addr[s] = '0;
    end
    repeat (3) @(negedge clk);
    chk(ack == '0 && !mem_en, "R10", "idle in reset", {ack, mem_en}, 0);
    chk(done == '0, "R10", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: size registers reset to zero, so a request completes with no access
    req[0] = 1'b1;
    step();
    chk(done[0] == 1'b1 && acks[0] == 0, "R10", "zero size after reset", acks[0], 0);
    req[0] = 1'b0;
    step();

    cfg(0, 1'b0, 16'h0100); cfg(0, 1'b1, 16'd3);
    cfg(1, 1'b0, 16'h0200); cfg(1, 1'b1, 16'd5);
    cfg(2, 1'b0, 16'h0300); cfg(2, 1'b1, 16'd1);
    cfg(3, 1'b0, 16'hFFFE); cfg(3, 1'b1, 16'd0);

    // R6: five-word read block
    zero_acks();
    req[1] = 1'b1;
    run_to_done(1, 20, "R6");
    chk(acks[1] == 5, "R6", "block word count", acks[1], 5);
    chk(last_addr[1] == 16'h0204, "R5", "last address", last_addr[1], 16'h0204);
    repeat (3) step();
    chk(acks[1] == 5, "R8", "no access while done", acks[1], 5);
    req[1] = 1'b0;
    step();
    chk(done[1] == 1'b0, "R8", "done clears on release", done[1], 0);

    // R6: single-word write to P space
    zero_acks();
    req[2] = 1'b1;
    run_to_done(2, 10, "R6");
    chk(acks[2] == 1, "R6", "single word", acks[2], 1);
    req[2] = 1'b0;
    step();

    // R7: zero-size block
    zero_acks();
    req[3] = 1'b1;
    step();
    chk(done[3] == 1'b1, "R7", "zero size done", done[3], 1);
    chk(acks[3] == 0, "R7", "zero size no access", acks[3], 0);
    req[3] = 1'b0;
    step();

    // R2: source 0 preempts source 1 at a word boundary
    zero_acks();
    req[1] = 1'b1;
    step(); step();
    req[0] = 1'b1;
    run_to_done(0, 10, "R2");
    chk(acks[0] == 3 && acks[1] == 2, "R2", "preempt counts", acks[1], 2);
    run_to_done(1, 10, "R2");
    chk(acks[1] == 5, "R2", "resumed total", acks[1], 5);
    req[0] = 1'b0; req[1] = 1'b0;
    step();

    // R9: pause and resume
    zero_acks();
    req[1] = 1'b1;
    step(); step();
    req[1] = 1'b0;
    repeat (3) step();
    chk(acks[1] == 2, "R9", "no words while paused", acks[1], 2);
    req[1] = 1'b1;
    step();
    chk(last_addr[1] == 16'h0202, "R9", "resume address", last_addr[1], 16'h0202);
    run_to_done(1, 10, "R9");
    chk(acks[1] == 5, "R9", "resumed count", acks[1], 5);

    // R8 then R1: clear with request held restarts; size rewrite mid-block
    zero_acks();
    done_clr[1] = 1'b1;
    step();
    done_clr[1] = 1'b0;
    step();
    chk(last_addr[1] == 16'h0200, "R8", "restart at base", last_addr[1], 16'h0200);
    cfg(1, 1'b1, 16'd2);
    run_to_done(1, 10, "R1");
    chk(acks[1] == 5, "R1", "mid-block size write ignored", acks[1], 5);
    zero_acks();
    done_clr[1] = 1'b1;
    step();
    done_clr[1] = 1'b0;
    run_to_done(1, 10, "R1");
    chk(acks[1] == 2, "R1", "new size used", acks[1], 2);
    req[1] = 1'b0;
    step();

    // all sources together; source 3 wraps the address space
    cfg(3, 1'b1, 16'd3);
    zero_acks();
    req = 4'b1111;
    run_to_done(3, 40, "R2");
    chk(acks[0] == 3 && acks[1] == 2 && acks[2] == 1 && acks[3] == 3, "R2",
        "shared counts", {acks[0][3:0], acks[1][3:0], acks[2][3:0], acks[3][3:0]}, 16'h3213);
    chk(last_addr[3] == 16'h0000, "R5", "address wrap", last_addr[3], 16'h0000);
    req = '0;
    step();
    chk(done == '0, "R8", "all cleared", done, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule